// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block watches sixteen interrupt request lines, each carrying an 8-bit priority value. It picks the most urgent pending request and decides whether that request may be taken now. A lower numeric priority value means higher urgency. A 3-bit split setting divides every priority value into an upper group field and a lower subpriority field. The winner is chosen on the whole value: group first, then subpriority, then the lowest request number.

Whether the winner may interrupt the handler that is already running depends on the group field alone. The winner must also pass a global mask and a base-priority threshold. The winning number, its priority and a take strobe are registered, so they appear one clock after the inputs are sampled. The number and priority are reloaded only in cycles where take is asserted, and otherwise keep their last value. Saving state, fetching vectors and decoding a register bus are outside this block.

Top module: `irq_grp_arb`

## Requirements
- R1: With split setting k (0..7), the subpriority field is the low k+1 bits of a priority value and the group field is the bits above them. The group value used in comparisons is the priority with those low k+1 bits cleared. For k = 7 every group value is zero.
- R2: Only requests whose pending bit is 1 take part. The winner is the one with the numerically smallest 8-bit priority, which orders by group and then by subpriority. Among equal values, the lowest request number wins.
- R3: While the handler flag is 1, take is asserted only if the winner's group value is strictly less than the group value of the active priority. An equal group never preempts, even when the subpriority is better.
- R4: While the handler flag is 0 (thread state), a pending winner that passes both masks is always taken.
- R5: While the global mask input is 1, take is never asserted.
- R6: A base-mask value of zero imposes no limit. A nonzero value blocks the winner when its group value is greater than or equal to the base-mask value.
- R7: With no pending request, take is 0.
- R8: Take, number and priority are registered. They reflect the inputs present at the preceding rising clock edge.
- R9: The number and priority outputs load the winner only in cycles where take is 1. While take is 0 they hold their previous values.
- R10: Under synchronous active-low reset, take, number and priority all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 16 | Pending bit per request line |
| prio_i | input | 128 | Priority values; line i is at bits [8i+7:8i] |
| split_i | input | 3 | Group/subpriority split setting k |
| act_prio_i | input | 8 | Priority of the handler now running |
| in_handler_i | input | 1 | 1 = a handler is running, 0 = thread state |
| gmask_i | input | 1 | 1 = block every request |
| base_mask_i | input | 8 | Base-priority threshold, 0 = off |
| win_id_o | output | 4 | Number of the last taken request |
| win_prio_o | output | 8 | Priority of the last taken request |
| take_o | output | 1 | Take strobe for the registered winner |

## Verification
Selection among pending requests and the preemption decision both act in the same cycle. A request that wins the ordering on subpriority can still be refused because its group matches the running handler. The bench provokes this with directed cases in which several requests share one group as the active priority but have different subpriorities, across several split settings including k = 7. The random phase narrows the priority range so that ties on group and on full value are frequent. A bench model computes the expected winner and take decision independently, and the registered number and priority are judged against the held or reloaded value one clock later.

// File: rtl/irq_grp_pkg.sv
// Package: shared sizes, candidate type and group-field helper for the
// grouped-priority interrupt arbiter. Assumes a power-of-two line count.
package irq_grp_pkg;

    localparam int IRQ_N   = 16;
    localparam int PRIO_W  = 8;
    localparam int SPLIT_W = 3;
    localparam int IRQ_IDW = $clog2(IRQ_N);
    localparam int NODES   = 2 * IRQ_N - 1;

    typedef struct packed {
        logic               vld;
        logic [IRQ_IDW-1:0] id;
        logic [PRIO_W-1:0]  prio;
    } cand_t;

    // Clears the k+1 subpriority bits, leaving the group field in place.
    function automatic logic [PRIO_W-1:0] group_of(input logic [PRIO_W-1:0] p,
                                                   input logic [SPLIT_W-1:0] k);
        logic [PRIO_W:0] lowm;
        lowm = ((PRIO_W+1)'(1) << (int'(k) + 1)) - (PRIO_W+1)'(1);
        return p & ~lowm[PRIO_W-1:0];
    endfunction

endpackage

// File: rtl/irq_grp_pick.sv
// Module: irq_grp_pick
// Picks the pending request with the smallest priority value, ties going to
// the lowest line number, through a binary compare tree stored heap-style.
// Assumes IRQ_N is a power of two. Purely combinational; the clock is used
// only by the embedded checks.
module irq_grp_pick
    import irq_grp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IRQ_N-1:0]         pend_i,
    input  logic [IRQ_N*PRIO_W-1:0]  prio_i,
    output cand_t                    win_o
);

    cand_t node [NODES];

    // Leaves: one candidate per request line, at heap slots N-1 .. 2N-2.
    for (genvar i = 0; i < IRQ_N; i++) begin : g_leaf
        assign node[IRQ_N-1+i] = '{vld: pend_i[i],
                                   id: IRQ_IDW'(i),
                                   prio: prio_i[i*PRIO_W +: PRIO_W]};
    end

    // Inner nodes: the left child (lower numbers) wins ties.
    for (genvar k = 0; k < IRQ_N - 1; k++) begin : g_cmp
        cand_t lft, rgt;
        assign lft = node[2*k+1];
        assign rgt = node[2*k+2];
        assign node[k] = (lft.vld && (!rgt.vld || lft.prio <= rgt.prio)) ? lft : rgt;
    end

    assign win_o = node[0];

    // R2 checks: the winner is never beaten by a pending line, and it is pending itself.
    for (genvar i = 0; i < IRQ_N; i++) begin : g_chk
        p_min_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pend_i[i] |-> (win_o.vld && win_o.prio <= prio_i[i*PRIO_W +: PRIO_W]
                           && (win_o.prio != prio_i[i*PRIO_W +: PRIO_W]
                               || int'(win_o.id) <= i)));
    end

    p_win_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_o.vld |-> pend_i[win_o.id]);

endmodule

// File: rtl/irq_grp_gate.sv
// Module: irq_grp_gate
// Decides whether the selected winner may be taken. The global mask and the
// base threshold are applied, and while a handler runs the winner's group
// field must beat the active group. Combinational.
module irq_grp_gate
    import irq_grp_pkg::*;
(
    input  cand_t               win_i,
    input  logic [SPLIT_W-1:0]  split_i,
    input  logic [PRIO_W-1:0]   act_prio_i,
    input  logic                in_handler_i,
    input  logic                gmask_i,
    input  logic [PRIO_W-1:0]   base_mask_i,
    output logic                take_o
);

    logic [PRIO_W-1:0] grp_win, grp_act;
    logic              mask_ok, preempt_ok;

    // Group fields of the candidate and of the running handler.
    always_comb begin
        grp_win = group_of(win_i.prio, split_i);
        grp_act = group_of(act_prio_i, split_i);
    end

    // Threshold and preemption tests, then the final take decision.
    always_comb begin
        mask_ok    = (base_mask_i == '0) || (grp_win < base_mask_i);
        preempt_ok = !in_handler_i || (grp_win < grp_act);
        take_o     = win_i.vld && !gmask_i && mask_ok && preempt_ok;
    end

endmodule

// File: rtl/irq_grp_arb.sv
// Module: irq_grp_arb (top)
// Grouped-priority interrupt arbiter: selection tree, take gate and output
// register. The number and priority load only when take is decided.
// Assumes inputs are synchronous to clk.
module irq_grp_arb
    import irq_grp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IRQ_N-1:0]         pend_i,
    input  logic [IRQ_N*PRIO_W-1:0]  prio_i,
    input  logic [SPLIT_W-1:0]       split_i,
    input  logic [PRIO_W-1:0]        act_prio_i,
    input  logic                     in_handler_i,
    input  logic                     gmask_i,
    input  logic [PRIO_W-1:0]        base_mask_i,
    output logic [IRQ_IDW-1:0]       win_id_o,
    output logic [PRIO_W-1:0]        win_prio_o,
    output logic                     take_o
);

    cand_t win;
    logic  take_c;

    irq_grp_pick u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_i),
        .prio_i (prio_i),
        .win_o  (win)
    );

    irq_grp_gate u_gate (
        .win_i        (win),
        .split_i      (split_i),
        .act_prio_i   (act_prio_i),
        .in_handler_i (in_handler_i),
        .gmask_i      (gmask_i),
        .base_mask_i  (base_mask_i),
        .take_o       (take_c)
    );

    // Output register: take every cycle, number/priority only on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            win_id_o   <= '0;
            win_prio_o <= '0;
        end else begin
            take_o <= take_c;
            if (take_c) begin
                win_id_o   <= win.id;
                win_prio_o <= win.prio;
            end
        end
    end

    // R9: number and priority stay put while take is low.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |=> ($stable(win_id_o) && $stable(win_prio_o)) || take_o);

    // R5: a global mask in the previous cycle forbids take now.
    p_gmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(gmask_i) |-> !take_o);

    // R3: a take during a handler means a strictly better group.
    p_group_preempt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && $past(in_handler_i) |->
            group_of(win_prio_o, $past(split_i)) < group_of($past(act_prio_i), $past(split_i)));

    // R6: a taken request beats any nonzero base threshold.
    p_base_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(base_mask_i) == '0)
                   || (group_of(win_prio_o, $past(split_i)) < $past(base_mask_i)));

    // R4: thread state with an unmasked pending request is always taken.
    p_thread_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!in_handler_i && (|pend_i) && !gmask_i && base_mask_i == '0)
        |-> take_o);

    // R7: nothing pending, nothing taken.
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(pend_i == '0) |-> !take_o);

endmodule

// File: tb/irq_grp_arb_tb.sv
`timescale 1ns/1ps
module irq_grp_arb_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [15:0]  pend;
    logic [127:0] prio;
    logic [2:0]   split;
    logic [7:0]   act_prio;
    logic         in_hdl;
    logic         gmask;
    logic [7:0]   base;
    logic [3:0]   win_id;
    logic [7:0]   win_prio;
    logic         take;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_id;
    logic [7:0] exp_prio;
    logic       exp_take;

    always #2 clk = ~clk;

    irq_grp_arb dut_i (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio), .split_i(split),
        .act_prio_i(act_prio), .in_handler_i(in_hdl), .gmask_i(gmask),
        .base_mask_i(base), .win_id_o(win_id), .win_prio_o(win_prio), .take_o(take)
    );

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Group value: priority with the low k+1 bits cleared (R1).
    function automatic logic [7:0] grp(input logic [7:0] p, input logic [2:0] k);
        logic [8:0] m;
        m = (9'd1 << (int'(k) + 1)) - 9'd1;
        return p & ~m[7:0];
    endfunction

    // Reference model: compute take and update the held number/priority.
    task automatic model();
        logic found = 1'b0;
        logic [3:0] bi = '0;
        logic [7:0] bp = '0;
        logic t;
        for (int i = 0; i < 16; i++) begin
            if (pend[i] && (!found || prio[i*8 +: 8] < bp)) begin
                found = 1'b1; bi = 4'(i); bp = prio[i*8 +: 8];
            end
        end
        t = found && !gmask
            && (base == 0 || grp(bp, split) < base)
            && (!in_hdl || grp(bp, split) < grp(act_prio, split));
        exp_take = t;
        if (t) begin exp_id = bi; exp_prio = bp; end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive inputs at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic step(input string req);
        model();
        @(negedge clk);
        chk({req, " take"}, 32'(take), 32'(exp_take));
        chk({req, " id"}, 32'(win_id), 32'(exp_id));
        chk({req, " prio"}, 32'(win_prio), 32'(exp_prio));
    endtask

    task automatic setp(input int i, input logic [7:0] v);
        prio[i*8 +: 8] = v;
    endtask

    task automatic clear();
        pend = '0; prio = {16{8'hF0}}; split = 3'd0; act_prio = 8'h00;
        in_hdl = 1'b0; gmask = 1'b0; base = 8'h00;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        clear();
        exp_id = '0; exp_prio = '0; exp_take = 1'b0;
        pend = 16'hFFFF;
        @(negedge clk); @(negedge clk);
        chk("R10 reset take", 32'(take), 0);
        chk("R10 reset id", 32'(win_id), 0);
        chk("R10 reset prio", 32'(win_prio), 0);
        rst_n = 1'b1;
        clear();

        // R7: nothing pending.
        step("R7 idle");

        // R2: tie on full value goes to the lowest number.
        pend = 16'b0010_0100_1000_0000; setp(7, 8'h40); setp(10, 8'h40); setp(13, 8'h40);
        step("R2 tie lowest");
        // R2/R4: smaller value wins, thread state takes.
        setp(13, 8'h3F);
        step("R4 thread take");
        // R8: a single-cycle request is visible exactly one edge later.
        clear(); pend[3] = 1'b1; setp(3, 8'h12);
        step("R8 latency");
        // R9: take falls, outputs hold.
        clear();
        step("R9 hold");

        // R3/R1: same group, better sub, split 3 (sub = low 4 bits) -> refused.
        clear(); in_hdl = 1'b1; split = 3'd3; act_prio = 8'h5C;
        pend[2] = 1'b1; setp(2, 8'h51);
        step("R3 equal group no preempt");
        // R3/R1: one group step better -> taken.
        setp(2, 8'h4F);
        step("R3 better group preempt");
        // R1: split 7 -> no group bits, never preempts.
        split = 3'd7; act_prio = 8'hFF; setp(2, 8'h00);
        step("R1 split7 no preempt");
        // R1: split 0 -> only bit 0 is sub: 0x5A vs active 0x5B same group.
        split = 3'd0; act_prio = 8'h5B; setp(2, 8'h5A);
        step("R1 split0 same group");
        setp(2, 8'h59);
        step("R1 split0 better group");

        // R6: base threshold boundary (group == base blocked, below passes).
        clear(); split = 3'd1; base = 8'h20; pend[9] = 1'b1; setp(9, 8'h23);
        step("R6 base equal blocked");
        setp(9, 8'h1F);
        step("R6 base below taken");
        // R5: global mask.
        gmask = 1'b1;
        step("R5 gmask blocks");

        // Random phase, narrow priority range to force ties.
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] rng;
            rng = 8'(($urandom % 3 == 0) ? 8'h0F : 8'hFF);
            pend = 16'($urandom) & 16'($urandom);
            for (int i = 0; i < 16; i++) setp(i, 8'($urandom) & rng);
            split = 3'($urandom);
            act_prio = 8'($urandom) & rng;
            in_hdl = 1'($urandom);
            gmask = ($urandom % 8) == 0;
            base = (($urandom % 3) == 0) ? (8'($urandom) & rng) : 8'h00;
            step("R2 R3 R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule